// File: doc/BRIEF.md
# Flash Status Register and Identification Responder

This block sits behind the byte-level SPI shifter of a serial flash device. It holds the status state that does not belong to the program/erase sequencer: the failure flag of the last program or erase, the reset-enable bit, the lockdown-enable bit and the deep power-down state. It streams the two status bytes and the three identification bytes back to the shifter. It accepts the write of the second status byte and decides whether a software reset request is genuine. The ready/busy, write-enable and protection-lock values come in live from outside and are only reported here.

The shifter hands over each complete received byte with a strobe while chip select is active. It raises a request each time it has taken an outgoing byte, and it reports whether the frame ended on a whole-byte boundary. The first byte of a frame is the opcode. Commands that change state at the end of a frame act on the cycle in which the block first sees chip select low.

Top module: `flash_stat_id`

## Requirements
- R1: Status byte 1 reads {sprl_in, 0, EPE, 0, 0, 0, wel_in, busy_in}, with bit 0 being busy and bit 7 being sprl.
- R2: Status byte 2 reads {0, 0, 0, RSTE, SLE, 0, 0, busy_in}, with RSTE at bit 4 and SLE at bit 3.
- R3: After opcode 05h, tx_valid is high and tx_byte shows status byte 1, then byte 2, alternating on every tx_next until chip select drops.
- R4: After opcode 9Fh, tx_byte shows 1Fh, 47h, 01h in turn on tx_next, and 00h after that.
- R5: Opcode 31h followed by a data byte loads RSTE from data bit 4 and SLE from data bit 3, but only when wel_in is 1 and busy_in is 0. Otherwise both bits keep their value.
- R6: After rst, RSTE, SLE and EPE are 0, deep_pd is 0, and tx_valid and soft_reset are low.
- R7: A frame of exactly F0h then D0h that ends on a whole byte while RSTE is 1 gives a single-cycle soft_reset pulse. The pulse appears the cycle after chip select is first seen low.
- R8: No pulse is given if RSTE is 0, if the confirmation byte is not D0h, if the frame ends mid-byte, or if the byte count is not two. A reset leaves RSTE and SLE unchanged.
- R9: On op_done, EPE takes the value of op_fail. At all other times EPE holds.
- R10: A frame holding only B9h and ending on a whole byte sets deep_pd, unless busy_in is 1. In that case the command is ignored.
- R11: While deep_pd is 1, every opcode other than ABh is ignored: tx_valid stays low, 31h writes nothing and no reset pulse is produced. A frame starting with ABh clears deep_pd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_sel | input | 1 | Chip select, 1 while the device is selected |
| bit_aligned | input | 1 | 1 when no partial byte is pending in the shifter |
| rx_valid | input | 1 | Strobe for one complete received byte |
| rx_byte | input | 8 | Received byte |
| tx_next | input | 1 | Shifter has taken tx_byte; advance the stream |
| wel_in | input | 1 | Write-enable latch value |
| sprl_in | input | 1 | Protection-register lock value |
| busy_in | input | 1 | Program/erase in progress |
| op_done | input | 1 | Program/erase finished this cycle |
| op_fail | input | 1 | Failure result qualified by op_done |
| tx_byte | output | 8 | Byte for the shifter to send |
| tx_valid | output | 1 | A read stream is active |
| soft_reset | output | 1 | One-cycle software reset pulse |
| deep_pd | output | 1 | Deep power-down state |

## Verification
A status read can be running in the very cycle the sequencer reports completion. The EPE update and the stream advance then land on the same edge. The bench provokes this by raising op_done with op_fail and tx_next together in the middle of a status read. It then expects the byte-2 slot to follow at once, and the next byte-1 slot to already show the new failure flag. A second overlap is a deep power-down request ending while busy is high, which must leave deep_pd low.

// File: rtl/fsid_pkg.sv
package fsid_pkg;
    localparam int BYTE_W   = 8;
    localparam int CNT_W    = 2;
    localparam int ID_LEN   = 3;
    localparam int RIDX_W   = $clog2(ID_LEN + 1);

    localparam logic [BYTE_W-1:0] OP_RDSR   = 8'h05;
    localparam logic [BYTE_W-1:0] OP_WRSR2  = 8'h31;
    localparam logic [BYTE_W-1:0] OP_SRST   = 8'hF0;
    localparam logic [BYTE_W-1:0] OP_RDID   = 8'h9F;
    localparam logic [BYTE_W-1:0] OP_DPD    = 8'hB9;
    localparam logic [BYTE_W-1:0] OP_WAKE   = 8'hAB;
    localparam logic [BYTE_W-1:0] SRST_CONF = 8'hD0;

    typedef struct packed {
        logic [BYTE_W-1:0] op;
        logic [BYTE_W-1:0] arg;
        logic [CNT_W-1:0]  cnt;
    } frame_t;

    typedef enum logic [1:0] {RD_NONE, RD_STAT, RD_ID} rd_mode_e;

    function automatic logic [BYTE_W-1:0] id_byte(input logic [RIDX_W-1:0] idx);
        case (idx)
            0:       return 8'h1F;
            1:       return 8'h47;
            2:       return 8'h01;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [BYTE_W-1:0] stat_b1(input logic busy, input logic wel,
                                                  input logic epe, input logic sprl);
        return {sprl, 1'b0, epe, 3'b000, wel, busy};
    endfunction

    function automatic logic [BYTE_W-1:0] stat_b2(input logic busy, input logic rste,
                                                  input logic sle);
        return {3'b000, rste, sle, 2'b00, busy};
    endfunction
endpackage

// File: rtl/fsid_frame.sv
module fsid_frame
    import fsid_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_sel,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    output frame_t            frm,
    output logic              cs_end
);
    logic cs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_q <= 1'b0;
            frm  <= '0;
        end else begin
            cs_q <= cs_sel;
            if (!cs_sel) begin
                frm.cnt <= '0;
            end else if (rx_valid) begin
                if (frm.cnt == 0) frm.op  <= rx_byte;
                if (frm.cnt == 1) frm.arg <= rx_byte;
                if (frm.cnt != {CNT_W{1'b1}}) frm.cnt <= frm.cnt + 1'b1;
            end
        end
    end

    assign cs_end = cs_q && !cs_sel;

    // R3
    frame_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !cs_sel |=> (frm.cnt == 0));
endmodule

// File: rtl/fsid_state.sv
module fsid_state
    import fsid_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_sel,
    input  logic              cs_end,
    input  logic              bit_aligned,
    input  frame_t            frm,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              wel_in,
    input  logic              busy_in,
    input  logic              op_done,
    input  logic              op_fail,
    output logic              rste,
    output logic              sle,
    output logic              epe,
    output logic              dpd,
    output logic              soft_reset
);
    logic wr_hit, end_ok, rst_hit, dpd_set, dpd_clr;

    always_comb begin
        wr_hit  = cs_sel && rx_valid && (frm.cnt == 1) && (frm.op == OP_WRSR2)
                  && wel_in && !busy_in && !dpd;
        end_ok  = cs_end && bit_aligned && (frm.cnt != 0);
        rst_hit = end_ok && !dpd && rste && (frm.op == OP_SRST)
                  && (frm.cnt == 2) && (frm.arg == SRST_CONF);
        dpd_set = end_ok && !dpd && (frm.op == OP_DPD) && (frm.cnt == 1) && !busy_in;
        dpd_clr = end_ok && dpd && (frm.op == OP_WAKE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rste       <= 1'b0;
            sle        <= 1'b0;
            epe        <= 1'b0;
            dpd        <= 1'b0;
            soft_reset <= 1'b0;
        end else begin
            if (wr_hit) begin
                rste <= rx_byte[4];
                sle  <= rx_byte[3];
            end
            if (op_done) epe <= op_fail;
            if (dpd_set)      dpd <= 1'b1;
            else if (dpd_clr) dpd <= 1'b0;
            soft_reset <= rst_hit;
        end
    end

    // R5
    wr_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable({rste, sle}) |-> $past(wel_in && !busy_in && !dpd));
    // R7
    pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
        soft_reset |=> !soft_reset);
    // R8
    reset_enable_chk: assert property (@(posedge clk) disable iff (rst)
        soft_reset |-> rste);
    // R9
    epe_capture_chk: assert property (@(posedge clk) disable iff (rst)
        op_done |=> (epe == $past(op_fail)));
    // R10
    dpd_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(dpd) |-> $past(!busy_in));
endmodule

// File: rtl/fsid_txmux.sv
module fsid_txmux
    import fsid_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_sel,
    input  logic [BYTE_W-1:0] op,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              dpd,
    input  logic              tx_next,
    input  logic              busy_in,
    input  logic              wel_in,
    input  logic              sprl_in,
    input  logic              epe,
    input  logic              rste,
    input  logic              sle,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              tx_valid
);
    rd_mode_e          mode;
    logic [RIDX_W-1:0] ridx;

    always_comb begin
        mode = RD_NONE;
        if (cs_sel && (cnt != 0) && !dpd) begin
            if (op == OP_RDSR)      mode = RD_STAT;
            else if (op == OP_RDID) mode = RD_ID;
        end
        tx_valid = (mode != RD_NONE);
        case (mode)
            RD_STAT: tx_byte = ridx[0] ? stat_b2(busy_in, rste, sle)
                                       : stat_b1(busy_in, wel_in, epe, sprl_in);
            RD_ID:   tx_byte = id_byte(ridx);
            default: tx_byte = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || !cs_sel) begin
            ridx <= '0;
        end else if (tx_next && tx_valid) begin
            if (mode == RD_STAT)           ridx <= {{(RIDX_W-1){1'b0}}, ~ridx[0]};
            else if (ridx != RIDX_W'(ID_LEN)) ridx <= ridx + 1'b1;
        end
    end

    // R11
    dpd_silent_chk: assert property (@(posedge clk) disable iff (rst)
        dpd |-> !tx_valid);
    // R4
    id_tail_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == RD_ID && ridx == RIDX_W'(ID_LEN)) |-> (tx_byte == 8'h00));
endmodule

// File: rtl/flash_stat_id.sv
module flash_stat_id
    import fsid_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_sel,
    input  logic              bit_aligned,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              tx_next,
    input  logic              wel_in,
    input  logic              sprl_in,
    input  logic              busy_in,
    input  logic              op_done,
    input  logic              op_fail,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              tx_valid,
    output logic              soft_reset,
    output logic              deep_pd
);
    frame_t frm;
    logic   cs_end, rste, sle, epe;

    fsid_frame u_frame (
        .clk(clk), .rst(rst), .cs_sel(cs_sel), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .frm(frm), .cs_end(cs_end)
    );

    fsid_state u_state (
        .clk(clk), .rst(rst), .cs_sel(cs_sel), .cs_end(cs_end),
        .bit_aligned(bit_aligned), .frm(frm), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .wel_in(wel_in), .busy_in(busy_in),
        .op_done(op_done), .op_fail(op_fail), .rste(rste), .sle(sle),
        .epe(epe), .dpd(deep_pd), .soft_reset(soft_reset)
    );

    fsid_txmux u_tx (
        .clk(clk), .rst(rst), .cs_sel(cs_sel), .op(frm.op), .cnt(frm.cnt),
        .dpd(deep_pd), .tx_next(tx_next), .busy_in(busy_in), .wel_in(wel_in),
        .sprl_in(sprl_in), .epe(epe), .rste(rste), .sle(sle),
        .tx_byte(tx_byte), .tx_valid(tx_valid)
    );
endmodule

// File: tb/tb_flash_stat_id.sv
module tb_flash_stat_id;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_sel = 1'b0, bit_aligned = 1'b1, rx_valid = 1'b0, tx_next = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       wel_in = 1'b0, sprl_in = 1'b0, busy_in = 1'b0, op_done = 1'b0, op_fail = 1'b0;
    logic [7:0] tx_byte;
    logic       tx_valid, soft_reset, deep_pd;

    int checks = 0;
    int errors = 0;
    logic pulse;
    logic [7:0] b;

    // {wel, sprl, busy, expected status byte 1}
    localparam logic [10:0] VEC [4] = '{
        {3'b100, 8'h02}, {3'b010, 8'h80}, {3'b111, 8'h83}, {3'b001, 8'h01}
    };

    flash_stat_id dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic cs_on();
        @(negedge clk); cs_sel = 1'b1;
    endtask

    task automatic send(input logic [7:0] v);
        @(negedge clk); rx_valid = 1'b1; rx_byte = v;
        @(negedge clk); rx_valid = 1'b0;
    endtask

    task automatic adv();
        tx_next = 1'b1; @(negedge clk); tx_next = 1'b0;
    endtask

    task automatic cs_off(input logic al, output logic p);
        @(negedge clk); cs_sel = 1'b0; bit_aligned = al;
        @(negedge clk); p = soft_reset; bit_aligned = 1'b1;
        @(negedge clk);
    endtask

    task automatic read_b2(output logic [7:0] v);
        logic p;
        cs_on(); send(8'h05); adv(); v = tx_byte; cs_off(1'b1, p);
    endtask

    task automatic wr_b2(input logic [7:0] v);
        logic p;
        cs_on(); send(8'h31); send(v); cs_off(1'b1, p);
    endtask

    task automatic frame_rst(input logic [7:0] c, input logic al, output logic p);
        cs_on(); send(8'hF0); send(c); cs_off(al, p);
    endtask

    task automatic one_op(input logic [7:0] op);
        logic p;
        cs_on(); send(op); cs_off(1'b1, p);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R6 reset state
        chk("R6 tx_valid", {7'd0, tx_valid}, 8'h00);
        chk("R6 soft_reset", {7'd0, soft_reset}, 8'h00);
        chk("R6 deep_pd", {7'd0, deep_pd}, 8'h00);
        read_b2(b);
        chk("R6 byte2", b, 8'h00);

        // R1 R3 table walk: byte1, byte2, byte1, byte2
        for (int i = 0; i < 4; i++) begin
            wel_in = VEC[i][10]; sprl_in = VEC[i][9]; busy_in = VEC[i][8];
            cs_on(); send(8'h05);
            chk("R3 valid", {7'd0, tx_valid}, 8'h01);
            chk("R1 byte1", tx_byte, VEC[i][7:0]);
            adv(); chk("R3 byte2", tx_byte, {7'd0, VEC[i][8]});
            adv(); chk("R3 repeat1", tx_byte, VEC[i][7:0]);
            adv(); chk("R3 repeat2", tx_byte, {7'd0, VEC[i][8]});
            cs_off(1'b1, pulse);
            chk("R3 ends", {7'd0, tx_valid}, 8'h00);
        end
        wel_in = 1'b0; sprl_in = 1'b0; busy_in = 1'b0;

        // R4 identification
        cs_on(); send(8'h9F);
        chk("R4 id0", tx_byte, 8'h1F); adv();
        chk("R4 id1", tx_byte, 8'h47); adv();
        chk("R4 id2", tx_byte, 8'h01); adv();
        chk("R4 id3", tx_byte, 8'h00); adv();
        chk("R4 id4", tx_byte, 8'h00);
        cs_off(1'b1, pulse);

        // R5 write gating
        wr_b2(8'h18); read_b2(b); chk("R5 no wel", b, 8'h00);
        wel_in = 1'b1; busy_in = 1'b1;
        wr_b2(8'h18); busy_in = 1'b0; read_b2(b); chk("R5 busy", b, 8'h00);
        wr_b2(8'h18); read_b2(b); chk("R2 R5 written", b, 8'h18);

        // R9 EPE capture
        @(negedge clk); op_done = 1'b1; op_fail = 1'b1;
        @(negedge clk); op_done = 1'b0; op_fail = 1'b0;
        cs_on(); send(8'h05); chk("R9 epe set", tx_byte, 8'h22);
        // overlap: op_done with stream advance
        op_done = 1'b1; op_fail = 1'b0; adv(); op_done = 1'b0;
        chk("R9 overlap b2", tx_byte, 8'h18);
        adv(); chk("R9 epe cleared", tx_byte, 8'h02);
        cs_off(1'b1, pulse);
        @(negedge clk); op_fail = 1'b1;
        @(negedge clk); op_fail = 1'b0;
        cs_on(); send(8'h05); chk("R9 hold", tx_byte, 8'h02); cs_off(1'b1, pulse);

        // R7 R8 software reset
        frame_rst(8'hD0, 1'b1, pulse); chk("R7 pulse", {7'd0, pulse}, 8'h01);
        @(negedge clk); chk("R7 single", {7'd0, soft_reset}, 8'h00);
        read_b2(b); chk("R8 bits kept", b, 8'h18);
        frame_rst(8'hD1, 1'b1, pulse); chk("R8 bad conf", {7'd0, pulse}, 8'h00);
        frame_rst(8'hD0, 1'b0, pulse); chk("R8 misaligned", {7'd0, pulse}, 8'h00);
        cs_on(); send(8'hF0); send(8'hD0); send(8'h00); cs_off(1'b1, pulse);
        chk("R8 three bytes", {7'd0, pulse}, 8'h00);
        wr_b2(8'h08); frame_rst(8'hD0, 1'b1, pulse);
        chk("R8 rste off", {7'd0, pulse}, 8'h00);

        // R10 deep power-down entry
        wr_b2(8'h18);
        busy_in = 1'b1; one_op(8'hB9); busy_in = 1'b0;
        chk("R10 busy refused", {7'd0, deep_pd}, 8'h00);
        one_op(8'hB9); chk("R10 entered", {7'd0, deep_pd}, 8'h01);

        // R11 deep power-down ignores commands
        cs_on(); send(8'h05); chk("R11 no read", {7'd0, tx_valid}, 8'h00); cs_off(1'b1, pulse);
        frame_rst(8'hD0, 1'b1, pulse); chk("R11 no reset", {7'd0, pulse}, 8'h00);
        wr_b2(8'h00);
        one_op(8'hAB); chk("R11 wake", {7'd0, deep_pd}, 8'h00);
        read_b2(b); chk("R11 write ignored", b, 8'h18);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule